// File: doc/BRIEF.md
# Start-Triggered Counting Sequencer

This block pairs a three-state control unit with a small datapath made of a 4-bit counter and two single-bit flags. While idle it waits for a start request. When start is seen, it clears the counter and the completion flag. It then counts upward once per clock. On every counting cycle the tracking flag takes the value of counter bit 1. Bit 0 is the least significant bit.

Counting ends once counter bits 1 and 2 are both set. After that the block spends one cycle in a final state, where it raises the completion flag, and then returns to idle. Every decision looks at register contents from before the clock edge. All updates that belong to one state land together on a single edge. The current state is visible on three one-hot indicator outputs.

Top module: `asm_count_sys`

## Requirements
- R1: While rst_ni is low, the block is idle (st_idle_o=1, the other two indicators 0), and count_o, track_o and done_flag_o are all 0. This takes effect without waiting for a clock edge.
- R2: In idle with start_i=0, a clock edge leaves the state, count_o, track_o and done_flag_o unchanged.
- R3: In idle with start_i=1, a clock edge moves to counting, sets count_o to 0 and done_flag_o to 0, and leaves track_o unchanged.
- R4: In counting, each clock edge increments count_o by 1.
- R5: In counting, each clock edge loads track_o with bit 1 of the count_o value present before that edge.
- R6: In counting, the next state is final when bits 1 and 2 of count_o are both 1 before the edge. Otherwise the block stays in counting.
- R7: In final, the next edge sets done_flag_o to 1, keeps count_o and track_o, and returns to idle whatever start_i is.
- R8: Exactly one of st_idle_o, st_count_o and st_final_o is 1 at all times.
- R9: start_i has no effect while counting.
- R10: A run started from count 0 spends seven cycles in counting and one in final, and ends in idle with count_o=7, track_o=1 and done_flag_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle |
| count_o | output | 4 | Counter value |
| track_o | output | 1 | Tracking flag, loaded from counter bit 1 |
| done_flag_o | output | 1 | Completion flag, set in the final state |
| st_idle_o | output | 1 | Idle state indicator |
| st_count_o | output | 1 | Counting state indicator |
| st_final_o | output | 1 | Final state indicator |

## Verification
The bench follows every cycle of two complete runs, so it catches a design whose tracking flag or exit test uses the value being written instead of the registered one. Such a design would be off by one in both the flag pattern and the final count. A second start while counting and a start held high through the final state are both checked: a wrong design would restart the counter or skip idle. The bench also checks that starting from a finished run keeps the old tracking value, where a design that cleared it would show 0, and it applies reset in the middle of a run.

// File: rtl/asm_count_pkg.sv
package asm_count_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_COUNT = 2'b01,
    ST_FINAL = 2'b11
  } seq_state_e;
endpackage

// File: rtl/asm_count_ctrl.sv
module asm_count_ctrl
  import asm_count_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic st_idle_o,
  output logic st_count_o,
  output logic st_final_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    case (state_q)
      ST_IDLE:  state_d = start_i ? ST_COUNT : ST_IDLE;
      ST_COUNT: state_d = stop_i ? ST_FINAL : ST_COUNT;
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE; // unused code 10 recovers to idle
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign st_idle_o  = (state_q == ST_IDLE);
  assign st_count_o = (state_q == ST_COUNT);
  assign st_final_o = (state_q == ST_FINAL);

  AST_ONE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({st_idle_o, st_count_o, st_final_o}) == 1); // R8
  AST_IDLE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_idle_o && !start_i |=> st_idle_o); // R2
  AST_FINAL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_final_o |=> st_idle_o); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_count_o && !stop_i |=> st_count_o); // R9
endmodule

// File: rtl/asm_count_dpath.sv
module asm_count_dpath #(
  parameter int unsigned           CNT_W     = 4,
  parameter int unsigned           TRACK_IDX = 1,
  parameter logic [CNT_W-1:0]      STOP_MASK = 4'b0110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             st_idle_i,
  input  logic             st_count_i,
  input  logic             st_final_i,
  output logic [CNT_W-1:0] count_o,
  output logic             track_o,
  output logic             done_flag_o,
  output logic             stop_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             trk_q, fin_q;
  logic             clr_go;

  assign clr_go = st_idle_i && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      trk_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      if (clr_go) begin
        cnt_q <= '0;
        fin_q <= 1'b0;
      end
      if (st_count_i) begin
        cnt_q <= cnt_q + CNT_ONE;
        trk_q <= cnt_q[TRACK_IDX];
      end
      if (st_final_i) fin_q <= 1'b1;
    end
  end

  assign stop_o      = (cnt_q & STOP_MASK) == STOP_MASK;
  assign count_o     = cnt_q;
  assign track_o     = trk_q;
  assign done_flag_o = fin_q;

  AST_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_idle_i && start_i |=> count_o == '0 && !done_flag_o && track_o == $past(track_o)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_count_i |=> count_o == $past(count_o) + CNT_ONE); // R4
  AST_TRACK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_count_i |=> track_o == $past(count_o[TRACK_IDX])); // R5
  AST_FINAL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_final_i |=> done_flag_o && $stable(count_o) && $stable(track_o)); // R7
endmodule

// File: rtl/asm_count_sys.sv
module asm_count_sys #(
  parameter int unsigned      CNT_W     = 4,
  parameter int unsigned      TRACK_IDX = 1,
  parameter logic [CNT_W-1:0] STOP_MASK = 4'b0110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CNT_W-1:0] count_o,
  output logic             track_o,
  output logic             done_flag_o,
  output logic             st_idle_o,
  output logic             st_count_o,
  output logic             st_final_o
);
  logic stop;

  asm_count_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop),
    .st_idle_o  (st_idle_o),
    .st_count_o (st_count_o),
    .st_final_o (st_final_o)
  );

  asm_count_dpath #(
    .CNT_W     (CNT_W),
    .TRACK_IDX (TRACK_IDX),
    .STOP_MASK (STOP_MASK)
  ) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .st_idle_i   (st_idle_o),
    .st_count_i  (st_count_o),
    .st_final_i  (st_final_o),
    .count_o     (count_o),
    .track_o     (track_o),
    .done_flag_o (done_flag_o),
    .stop_o      (stop)
  );

  AST_STOP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_count_o && count_o[1] && count_o[2] |=> st_final_o); // R6
endmodule

// File: tb/sim_asm_count_sys.sv
module sim_asm_count_sys;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  // {start, final, count, idle, count[3:0], track, done}, expected after the edge
  localparam logic [9:0] VEC [NV] = '{
    10'b0_001_0000_0_0, // R2 idle hold
    10'b1_010_0000_0_0, // R3 start
    10'b0_010_0001_0_0, // R4 R5
    10'b0_010_0010_0_0,
    10'b0_010_0011_1_0, // R5 bit1 of 2
    10'b0_010_0100_1_0,
    10'b0_010_0101_0_0,
    10'b0_010_0110_0_0, // R6 at 5 stays
    10'b0_100_0111_1_0, // R6 at 6 exits
    10'b0_001_0111_1_1, // R7 R10
    10'b0_001_0111_1_1, // R2
    10'b1_010_0000_1_0, // R3 track kept
    10'b1_010_0001_0_0, // R9
    10'b1_010_0010_0_0,
    10'b1_010_0011_1_0,
    10'b1_010_0100_1_0,
    10'b1_010_0101_0_0,
    10'b1_010_0110_0_0,
    10'b1_100_0111_1_0,
    10'b1_001_0111_1_1, // R7 start ignored in final
    10'b1_010_0000_1_0
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] count_o;
  logic       track_o, done_flag_o, st_idle_o, st_count_o, st_final_o;
  int         checks = 0;
  int         errors = 0;
  bit         fin_seen = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  asm_count_sys u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .count_o(count_o), .track_o(track_o), .done_flag_o(done_flag_o),
    .st_idle_o(st_idle_o), .st_count_o(st_count_o), .st_final_o(st_final_o)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [8:0] obs();
    return {st_final_o, st_count_o, st_idle_o, count_o, track_o, done_flag_o};
  endfunction

  initial begin
    int cnt_cycles;
    #(CLK_PERIOD * 3 + 2);
    chk("R1 reset", obs(), 9'b001_0000_0_0);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i) start_i = VEC[i][9];
      @(posedge clk_i) #(CLK_PERIOD/4);
      chk($sformatf("R2-7/R9 step %0d", i), obs(), VEC[i][8:0]);
      if ($countones(obs()[8:6]) != 1) chk("R8", obs(), VEC[i][8:0] ^ 9'h1c0);
      else chk("R8", 9'd0, 9'd0);
    end
    // R10: count the cycles of a full run from a fresh start
    @(negedge clk_i) start_i = 1'b0;
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    cnt_cycles = 0;
    while (st_count_o && cnt_cycles < 20) begin
      cnt_cycles++;
      @(negedge clk_i);
    end
    chk("R10 count cycles", 9'(cnt_cycles), 9'd7);
    chk("R10 final state", {st_final_o, 8'd0}, 9'h100);
    @(negedge clk_i);
    chk("R10 end", obs(), 9'b001_0111_1_1);
    // R1: asynchronous reset mid-run
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1;
    chk("R1 async mid-run", obs(), 9'b001_0000_0_0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i) #(CLK_PERIOD/4);
    chk("R1 R2 after reset", obs(), 9'b001_0000_0_0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    errors++;
    checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) if (st_final_o) fin_seen <= 1'b1;
endmodule